// File: doc/BRIEF.md
# Dual-Slot Receive Buffer Controller

This block is the register-mapped control core of a small Ethernet MAC. A host reaches it through a simple word-addressed register port. Through that port the host arms two receive buffer slots, reads back how many bytes landed in each one, starts transmissions and bit-bangs the PHY management lines. The frame datapath is a separate block. Each time it finishes storing a frame it raises a one-cycle strobe with the stored byte length. The controller then tells it which slot, and which buffer byte address, the frame belongs to.

Each slot runs a three-state handshake between host and hardware. The host marks a slot as armed. The hardware takes the lowest-numbered armed slot for the next frame, records the length and flags it as full. The host empties it again once the frame is consumed. The receive interrupt is a level that stays high while any slot holds a frame.

A nonzero write to the transmit length register starts a transmit check. The check tests the length against a legal window and tests the first eight bytes of the transmit buffer against the Ethernet preamble and start delimiter. Every check produces a transmit interrupt pulse, whether the frame was accepted or rejected.

Top module: `rxc_ctrl_core`

## Requirements
- R1: After reset every register reads zero, and rx_irq, rx_ready, tx_irq, tx_send, phy_rst, mdc, mdio_o and mdio_oe are all low.
- R2: Register word offsets are 0 setup, 1 management, 2 slot-0 state, 3 slot-0 count, 4 slot-1 state, 5 slot-1 count, 6 transmit length. A slot state register keeps write bits [1:0] with encoding 0 empty, 1 armed, 2 full, and its upper bits read zero. A slot count register keeps write bits [11:0].
- R3: A frame strobe goes to slot 0 if slot 0 is armed, else to slot 1 if slot 1 is armed. When neither slot is armed the frame is dropped and no register changes.
- R4: One clock after a frame strobe, the chosen slot's count equals the strobe length and its state reads 2 (full).
- R5: rx_irq is high exactly while at least one slot state reads 2. It follows both frame stores and host writes to state registers.
- R6: rx_ready is high while at least one slot is armed. rx_slot and rx_base give the slot that would take the next frame and its buffer byte address, slot index times 2048 (slot 0 at 0, slot 1 at 2048). Both read 0 when no slot is armed.
- R7: A nonzero write to the transmit length register is accepted when the value lies in 64 to 1530 inclusive and tx_hdr equals 64'hD555555555555555 (buffer byte 0 in bits [7:0], seven 0x55 bytes then 0xD5). On acceptance the register reads zero afterwards and tx_send pulses for one cycle.
- R8: Every nonzero write to the transmit length register gives a one-cycle tx_irq pulse in the cycle after the write, whether accepted or rejected. A rejected value stays readable. A write of zero stores zero and gives no pulse.
- R9: Management register bits are 0 data-out, 1 data-in, 2 output-enable and 3 clock. Bits 0, 2 and 3 drive mdio_o, mdio_oe and mdc. Bit 1 reads mdio_i through a two-flop synchronizer, and a host write never changes it.
- R10: Setup bit 0 drives phy_rst. The other setup bits read zero.
- R11: Offsets 7 and above read zero, and writes to them change no register.
- R12: When a host write to a slot's state register coincides with a frame strobe for that slot, the written state wins, while the count still records the frame length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register word offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| frm_valid | input | 1 | One-cycle strobe: a received frame has been stored |
| frm_len | input | 12 | Stored byte length of that frame |
| rx_ready | output | 1 | At least one slot is armed |
| rx_slot | output | 1 | Slot that takes the next frame |
| rx_base | output | 13 | Buffer byte address of that slot |
| rx_irq | output | 1 | Receive interrupt level |
| tx_hdr | input | 64 | First eight transmit buffer bytes, byte 0 in bits [7:0] |
| tx_send | output | 1 | One-cycle pulse: transmit accepted |
| tx_irq | output | 1 | One-cycle transmit interrupt pulse |
| phy_rst | output | 1 | PHY reset control |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
Frame strobes arrive under every mix of slot states, so the bench can tell slot-0-first priority apart from round-robin or last-armed choice. It can also tell a dropped frame apart from one written over a full slot. Transmit lengths are drawn at random and pinned at 63, 64, 1530 and 1531. Headers are either correct or corrupted in a single byte, which tells a length fault apart from a header fault. A zero write shows that the interrupt is tied to the check and not to any write. Host state writes that collide with strobes, management writes that try to set the data-in bit, and writes to unused offsets show which party owns each piece of state.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic [1:0] {
    SLOT_EMPTY   = 2'd0,
    SLOT_ARMED   = 2'd1,
    SLOT_FULL    = 2'd2,
    SLOT_UNUSED  = 2'd3
  } slot_state_e;

  localparam int OFS_SETUP     = 0;
  localparam int OFS_MGMT      = 1;
  localparam int OFS_SLOT_BASE = 2;

  localparam logic [63:0] TX_PREAMBLE = 64'hD555_5555_5555_5555;
endpackage

// File: rtl/rxc_slot.sv
module rxc_slot
  import rxc_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             state_we,
  input  logic             count_we,
  input  logic [31:0]      wdata,
  input  logic             take,
  input  logic [LEN_W-1:0] take_len,
  output slot_state_e      state_o,
  output logic [LEN_W-1:0] count_o
);
  slot_state_e      state_q, state_d;
  logic [LEN_W-1:0] count_q, count_d;
  logic             state_en, count_en;

  always_comb begin
    state_en = state_we | take;
    state_d  = state_q;
    if (state_we)  state_d = slot_state_e'(wdata[1:0]);
    else if (take) state_d = SLOT_FULL;
  end

  always_comb begin
    count_en = count_we | take;
    count_d  = count_q;
    if (count_we)  count_d = wdata[LEN_W-1:0];
    else if (take) count_d = take_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SLOT_EMPTY;
      count_q <= '0;
    end else begin
      if (state_en) state_q <= state_d;
      if (count_en) count_q <= count_d;
    end
  end

  assign state_o = state_q;
  assign count_o = count_q;
endmodule

// File: rtl/rxc_tx_check.sv
module rxc_tx_check
  import rxc_pkg::*;
#(
  parameter int TX_MIN = 64,
  parameter int TX_MAX = 1530
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic [63:0] hdr,
  output logic [31:0] count_o,
  output logic        irq_o,
  output logic        send_o
);
  logic [31:0] count_q, count_d;
  logic        irq_q, irq_d, send_q, send_d;
  logic        start, len_ok, hdr_ok, accept;

  always_comb begin
    start   = wr && (wdata != 32'd0);
    len_ok  = (wdata >= 32'(TX_MIN)) && (wdata <= 32'(TX_MAX));
    hdr_ok  = (hdr == TX_PREAMBLE);
    accept  = start && len_ok && hdr_ok;
    count_d = accept ? 32'd0 : wdata;
    irq_d   = start;
    send_d  = accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      irq_q   <= 1'b0;
      send_q  <= 1'b0;
    end else begin
      if (wr) count_q <= count_d;
      irq_q  <= irq_d;
      send_q <= send_d;
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;
  assign send_o  = send_q;
endmodule

// File: rtl/rxc_mgmt_port.sv
module rxc_mgmt_port (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [31:0] wdata,
  input  logic        pin_i,
  output logic        mdc_o,
  output logic        mdo_o,
  output logic        moe_o,
  output logic        mdi_o
);
  logic [2:0] ctl_q, ctl_d;
  logic       sync1_q, sync2_q;

  always_comb begin
    ctl_d = {wdata[3], wdata[2], wdata[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q   <= '0;
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
    end else begin
      if (wr) ctl_q <= ctl_d;
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
    end
  end

  assign mdc_o = ctl_q[2];
  assign moe_o = ctl_q[1];
  assign mdo_o = ctl_q[0];
  assign mdi_o = sync2_q;
endmodule

// File: rtl/rxc_ctrl_core.sv
module rxc_ctrl_core
  import rxc_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int BUF_BYTES = 2048,
  parameter int ADDR_W    = 4,
  parameter int TX_MIN    = 64,
  parameter int TX_MAX    = 1530,
  localparam int LEN_W    = $clog2(BUF_BYTES) + 1,
  localparam int SLOT_W   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1,
  localparam int BASE_W   = $clog2((NUM_SLOTS + 1) * BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              frm_valid,
  input  logic [LEN_W-1:0]  frm_len,
  output logic              rx_ready,
  output logic [SLOT_W-1:0] rx_slot,
  output logic [BASE_W-1:0] rx_base,
  output logic              rx_irq,
  input  logic [63:0]       tx_hdr,
  output logic              tx_send,
  output logic              tx_irq,
  output logic              phy_rst,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  localparam logic [ADDR_W-1:0] A_SETUP = ADDR_W'(OFS_SETUP);
  localparam logic [ADDR_W-1:0] A_MGMT  = ADDR_W'(OFS_MGMT);
  localparam logic [ADDR_W-1:0] A_TX    = ADDR_W'(OFS_SLOT_BASE + 2 * NUM_SLOTS);

  logic [NUM_SLOTS-1:0][1:0]       slot_st;
  logic [NUM_SLOTS-1:0][LEN_W-1:0] slot_cnt;
  logic [NUM_SLOTS-1:0]            slot_take;
  logic                            sel_valid;
  logic [SLOT_W-1:0]               sel_idx;
  logic [31:0]                     tx_count;
  logic                            mgmt_di;
  logic                            setup_q, setup_d, setup_we;
  logic                            any_full;

  // Lowest-numbered armed slot wins.
  always_comb begin
    sel_valid = 1'b0;
    sel_idx   = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (slot_state_e'(slot_st[i]) == SLOT_ARMED) begin
        sel_valid = 1'b1;
        sel_idx   = SLOT_W'(i);
      end
    end
  end

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(OFS_SLOT_BASE + 2 * g);
      localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(OFS_SLOT_BASE + 2 * g + 1);
      slot_state_e st_w;

      assign slot_take[g] = frm_valid && sel_valid && (sel_idx == SLOT_W'(g));

      rxc_slot #(.LEN_W(LEN_W)) u_slot (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_we (reg_we && (reg_addr == A_ST)),
        .count_we (reg_we && (reg_addr == A_CNT)),
        .wdata    (reg_wdata),
        .take     (slot_take[g]),
        .take_len (frm_len),
        .state_o  (st_w),
        .count_o  (slot_cnt[g])
      );
      assign slot_st[g] = st_w;
    end
  endgenerate

  rxc_tx_check #(.TX_MIN(TX_MIN), .TX_MAX(TX_MAX)) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (reg_we && (reg_addr == A_TX)),
    .wdata   (reg_wdata),
    .hdr     (tx_hdr),
    .count_o (tx_count),
    .irq_o   (tx_irq),
    .send_o  (tx_send)
  );

  rxc_mgmt_port u_mgmt (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (reg_we && (reg_addr == A_MGMT)),
    .wdata (reg_wdata),
    .pin_i (mdio_i),
    .mdc_o (mdc),
    .mdo_o (mdio_o),
    .moe_o (mdio_oe),
    .mdi_o (mgmt_di)
  );

  always_comb begin
    setup_we = reg_we && (reg_addr == A_SETUP);
    setup_d  = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        setup_q <= 1'b0;
    else if (setup_we) setup_q <= setup_d;
  end

  always_comb begin
    any_full = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (slot_state_e'(slot_st[i]) == SLOT_FULL) any_full = 1'b1;
  end

  always_comb begin
    reg_rdata = 32'd0;
    if (reg_addr == A_SETUP) reg_rdata = {31'd0, setup_q};
    if (reg_addr == A_MGMT)  reg_rdata = {28'd0, mdc, mdio_oe, mgmt_di, mdio_o};
    if (reg_addr == A_TX)    reg_rdata = tx_count;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (reg_addr == ADDR_W'(OFS_SLOT_BASE + 2 * i))
        reg_rdata = {30'd0, slot_st[i]};
      if (reg_addr == ADDR_W'(OFS_SLOT_BASE + 2 * i + 1))
        reg_rdata = {{(32 - LEN_W){1'b0}}, slot_cnt[i]};
    end
  end

  assign rx_ready = sel_valid;
  assign rx_slot  = sel_idx;
  assign rx_base  = BASE_W'(sel_idx) * BASE_W'(BUF_BYTES);
  assign rx_irq   = any_full;
  assign phy_rst  = setup_q;
endmodule

// File: rtl/rxc_ctrl_core_chk.sv
module rxc_ctrl_core_chk #(
  parameter int NUM_SLOTS = 2,
  parameter int ADDR_W    = 4,
  parameter int LEN_W     = 12
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [ADDR_W-1:0]               reg_addr,
  input logic                            reg_we,
  input logic [31:0]                     reg_wdata,
  input logic                            frm_valid,
  input logic [LEN_W-1:0]                frm_len,
  input logic                            rx_irq,
  input logic                            tx_irq,
  input logic                            tx_send,
  input logic [NUM_SLOTS-1:0][1:0]       slot_st,
  input logic [NUM_SLOTS-1:0][LEN_W-1:0] slot_cnt,
  input logic [31:0]                     tx_count
);
  localparam logic [ADDR_W-1:0] A_TX = ADDR_W'(2 + 2 * NUM_SLOTS);

  logic                 wr_state;
  logic [NUM_SLOTS-1:0] chosen;
  logic                 lower_armed;

  always_comb begin
    wr_state = reg_we && (reg_addr >= ADDR_W'(2)) && (reg_addr < A_TX) && !reg_addr[0];
    lower_armed = 1'b0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      chosen[i] = frm_valid && (slot_st[i] == 2'd1) && !lower_armed;
      if (slot_st[i] == 2'd1) lower_armed = 1'b1;
    end
  end

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_a
      // R3 and R4: the chosen slot turns full
      a_r3_slot_take: assert property (@(posedge clk) disable iff (!rst_n)
        chosen[g] && !(reg_we && reg_addr == ADDR_W'(2 + 2 * g)) |=> slot_st[g] == 2'd2);
      // R4: the count records the strobe length
      a_r4_count_take: assert property (@(posedge clk) disable iff (!rst_n)
        chosen[g] && !(reg_we && reg_addr == ADDR_W'(3 + 2 * g)) |=> slot_cnt[g] == $past(frm_len));
    end
  endgenerate

  // R3: with no armed slot a frame changes nothing
  a_r3_drop: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !lower_armed && !reg_we |=> $stable(slot_st) && $stable(slot_cnt));

  // R5: the level only rises after a store or a state write
  a_r5_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_irq) |-> $past(frm_valid || wr_state));

  // R8: the transmit interrupt follows a nonzero length write
  a_r8_tx_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> $past(reg_we && reg_addr == A_TX && reg_wdata != 32'd0));

  // R7: acceptance leaves the length register cleared
  a_r7_send_clears: assert property (@(posedge clk) disable iff (!rst_n)
    tx_send |-> tx_irq && tx_count == 32'd0);
endmodule

bind rxc_ctrl_core rxc_ctrl_core_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .ADDR_W    (ADDR_W),
  .LEN_W     (LEN_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .frm_valid (frm_valid),
  .frm_len   (frm_len),
  .rx_irq    (rx_irq),
  .tx_irq    (tx_irq),
  .tx_send   (tx_send),
  .slot_st   (slot_st),
  .slot_cnt  (slot_cnt),
  .tx_count  (tx_count)
);

// File: tb/rxc_ctrl_core_test.sv
module rxc_ctrl_core_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] GOOD_HDR = 64'hD555_5555_5555_5555;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frm_valid = 1'b0;
  logic [11:0] frm_len = '0;
  logic        rx_ready, rx_irq, tx_send, tx_irq, phy_rst, mdc, mdio_o, mdio_oe;
  logic [0:0]  rx_slot;
  logic [12:0] rx_base;
  logic [63:0] tx_hdr = '0;
  logic        mdio_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  // reference model
  logic [1:0]  m_st [2];
  logic [11:0] m_cnt [2];
  logic [31:0] m_tx;
  logic [2:0]  m_mgmt;
  logic        m_setup;
  logic        last_irq, last_send;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxc_ctrl_core uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_valid(frm_valid),
    .frm_len(frm_len), .rx_ready(rx_ready), .rx_slot(rx_slot), .rx_base(rx_base),
    .rx_irq(rx_irq), .tx_hdr(tx_hdr), .tx_send(tx_send), .tx_irq(tx_irq),
    .phy_rst(phy_rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(int a);
    case (a)
      0: return {31'd0, m_setup};
      1: return {28'd0, m_mgmt[2], m_mgmt[1], mdio_i, m_mgmt[0]};
      2: return {30'd0, m_st[0]};
      3: return {20'd0, m_cnt[0]};
      4: return {30'd0, m_st[1]};
      5: return {20'd0, m_cnt[1]};
      6: return m_tx;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic exp_irq();
    return (m_st[0] == 2'd2) || (m_st[1] == 2'd2);
  endfunction

  function automatic int exp_sel();
    if (m_st[0] == 2'd1) return 0;
    if (m_st[1] == 2'd1) return 1;
    return -1;
  endfunction

  function automatic logic tx_ok(logic [31:0] v, logic [63:0] h);
    return (v >= 32'd64) && (v <= 32'd1530) && (h == GOOD_HDR);
  endfunction

  task automatic model_write(int a, logic [31:0] d);
    case (a)
      0: m_setup = d[0];
      1: m_mgmt = {d[3], d[2], d[0]};
      2: m_st[0] = d[1:0];
      3: m_cnt[0] = d[11:0];
      4: m_st[1] = d[1:0];
      5: m_cnt[1] = d[11:0];
      6: m_tx = (d != 0 && tx_ok(d, tx_hdr)) ? 32'd0 : d;
      default: ;
    endcase
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    reg_addr = 4'(a); reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
    last_irq = tx_irq; last_send = tx_send;
    model_write(a, d);
  endtask

  task automatic rd_chk(string tag, int a);
    @(negedge clk);
    reg_addr = 4'(a);
    #1;
    chk(tag, reg_rdata, exp_read(a));
  endtask

  task automatic sweep(string tag);
    for (int a = 0; a < 16; a++) rd_chk(tag, a);
    chk({tag, " irq"}, {31'd0, rx_irq}, {31'd0, exp_irq()});
  endtask

  task automatic store(logic [11:0] len);
    int s;
    @(negedge clk);
    s = exp_sel();
    // R6: ready, slot and base address before the strobe
    chk("R6 rx_ready", {31'd0, rx_ready}, {31'd0, s >= 0});
    chk("R6 rx_base", {19'd0, rx_base}, (s >= 0) ? 32'(s * 2048) : 32'd0);
    chk("R6 rx_slot", {31'd0, rx_slot}, (s >= 0) ? 32'(s) : 32'd0);
    frm_valid = 1'b1; frm_len = len;
    @(negedge clk);
    frm_valid = 1'b0;
    if (s >= 0) begin
      m_st[s] = 2'd2;
      m_cnt[s] = len;
    end
    // R3/R4: slot that took the frame, or nothing on drop; R5 level
    rd_chk("R3 R4 state0", 2);
    rd_chk("R3 R4 count0", 3);
    rd_chk("R3 R4 state1", 4);
    rd_chk("R3 R4 count1", 5);
    chk("R5 rx_irq", {31'd0, rx_irq}, {31'd0, exp_irq()});
  endtask

  task automatic tx_try(logic [31:0] v, logic [63:0] h);
    logic ok;
    tx_hdr = h;
    ok = (v != 0) && tx_ok(v, h);
    wr(6, v);
    chk("R8 tx_irq", {31'd0, last_irq}, {31'd0, v != 0});
    chk("R7 tx_send", {31'd0, last_send}, {31'd0, ok});
    rd_chk("R7 R8 txlen", 6);
    @(negedge clk);
    chk("R8 tx_irq one cycle", {31'd0, tx_irq}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    m_st[0] = 0; m_st[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    m_tx = 0; m_mgmt = 0; m_setup = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    sweep("R1 reset");
    chk("R1 pins", {25'd0, rx_ready, rx_irq, tx_irq, tx_send, phy_rst, mdc, mdio_o | mdio_oe},
        32'd0);

    // R2 register readback and field masking
    wr(3, 32'hFFFF_F123); rd_chk("R2 count0 mask", 3);
    wr(4, 32'hFFFF_FFF2); rd_chk("R2 state1 mask", 4);
    wr(4, 0); wr(3, 0);

    // R3 priority: both armed -> slot 0 first, then slot 1, then drop
    wr(2, 1); wr(4, 1);
    store(12'd100);
    store(12'd200);
    store(12'd300);
    // R5 host clears one full slot: irq stays, then falls
    wr(2, 0); chk("R5 one full", {31'd0, rx_irq}, 32'd1);
    wr(4, 0); chk("R5 none full", {31'd0, rx_irq}, 32'd0);
    // only slot 1 armed
    wr(4, 1); store(12'd2048);
    wr(4, 0);

    // R12 collision of host state write and frame strobe on slot 0
    wr(2, 1);
    @(negedge clk);
    reg_addr = 4'd2; reg_wdata = 32'd0; reg_we = 1'b1;
    frm_valid = 1'b1; frm_len = 12'd77;
    @(negedge clk);
    reg_we = 1'b0; frm_valid = 1'b0;
    m_st[0] = 2'd0; m_cnt[0] = 12'd77;
    rd_chk("R12 state wins", 2);
    rd_chk("R12 count recorded", 3);

    // R7/R8 transmit boundaries
    tx_try(32'd63, GOOD_HDR);
    tx_try(32'd64, GOOD_HDR);
    tx_try(32'd1530, GOOD_HDR);
    tx_try(32'd1531, GOOD_HDR);
    tx_try(32'd500, GOOD_HDR ^ 64'h0000_0000_0000_0001);
    tx_try(32'd500, GOOD_HDR ^ 64'h8000_0000_0000_0000);
    tx_try(32'd0, GOOD_HDR);

    // R9 management: data-in follows the pin, not the write
    mdio_i = 1'b0;
    wr(1, 32'h0000_000F);
    rd_chk("R9 di write ignored", 1);
    chk("R9 pins", {29'd0, mdc, mdio_oe, mdio_o}, 32'd7);
    mdio_i = 1'b1;
    repeat (3) @(negedge clk);
    rd_chk("R9 di follows pin", 1);
    wr(1, 32'h0000_0000);
    rd_chk("R9 di kept", 1);

    // R10 setup
    wr(0, 32'hFFFF_FFFF); rd_chk("R10 setup", 0);
    chk("R10 phy_rst", {31'd0, phy_rst}, 32'd1);
    wr(0, 32'h0000_0000);
    chk("R10 phy_rst low", {31'd0, phy_rst}, 32'd0);

    // R11 undefined offsets
    for (int a = 7; a < 16; a++) wr(a, 32'hFFFF_FFFF);
    sweep("R11 undefined");

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: wr(2 + 2 * $urandom_range(0, 1), {$urandom_range(0, 32'hFFFF), 14'd0,
               2'($urandom_range(0, 2))});
        1: store(12'($urandom_range(60, 2048)));
        2: begin
          logic [31:0] v;
          logic [63:0] h;
          case ($urandom_range(0, 3))
            0: v = 32'($urandom_range(0, 70));
            1: v = 32'($urandom_range(1520, 1540));
            default: v = 32'($urandom_range(0, 3000));
          endcase
          h = ($urandom_range(0, 3) != 0) ? GOOD_HDR : (GOOD_HDR ^ (64'd1 << $urandom_range(0, 63)));
          tx_try(v, h);
        end
        3: begin
          mdio_i = 1'($urandom_range(0, 1));
          wr(1, $urandom);
          repeat (2) @(negedge clk);
          rd_chk("R9 random", 1);
        end
        4: begin wr(0, $urandom); rd_chk("R10 random", 0); end
        default: begin wr($urandom_range(7, 15), $urandom); rd_chk("R11 random", $urandom_range(0, 15)); end
      endcase
      chk("R5 random irq", {31'd0, rx_irq}, {31'd0, exp_irq()});
    end
    sweep("R2 final");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule